// File: doc/BRIEF.md
# Hexadecimal Floating-Point Multiplier (excess-64, single word)

This block multiplies two 32-bit hexadecimal floating-point words and returns a 32-bit product plus a 4-bit condition code. A word holds a sign in bit 31, a 7-bit exponent biased by 64 in bits 30:24, and a 24-bit fraction whose radix is 16. A negative value is the two's complement of the whole positive word. The block handles both signs and normalizes in steps of one hex digit. It rounds by the sign-dependent rule given below. When the exponent leaves its range it returns a fixed saturation word.

A caller pulses `start_i` with both operands on `a_i`/`b_i` while the block is idle. The block captures the operands and forms the full product one cycle later. In the next cycle it normalizes, rounds and repacks, then presents the result with a single-cycle `done_o`. A new operation may start in the same cycle that `done_o` is high.

Top module: `hxm_mul`

## Requirements
- R1: If either operand word is exactly zero, the result is 0x00000000 and cc is 4'b0001.
- R2: The result sign is the XOR of the operand sign bits. Each negative operand is negated as a whole word before its exponent and fraction are used. A normal negative result has bit 31 set and carries the bitwise complement of its 7-bit exponent (for example -1.0 x 1.0 = 0xBEF00000).
- R3: The final exponent is ea + eb - 128 + ne. Here ea and eb are the top bytes of the operand magnitudes, and ne is 64 minus the number of hex-digit normalization shifts (for example 1.0 x 1.0 = 0x41100000 and 15 x 15 = 0x42E10000).
- R4: Each fraction sits in bits 30:7 of a 32-bit word. The 64-bit product of the two is doubled and negated for a negative result, then shifted left four bits at a time while its top five bits are all equal. An upper product word of 0x80000000 becomes 0xF8000000, and ne grows by one. The packed fraction is bits 30:7 of the upper word.
- R5: If the upper product word is below 0x7FFFFFC0 (signed) and ne equals 64, 0x40 is added to it before packing; otherwise no rounding is applied (for example 0x41800001 x 0x41C00000 = 0x42600001).
- R6: A final exponent above 127 is overflow. The result is 0x7FFFFFFF with cc 4'b1101 for a positive sign, or 0x80000001 with cc 4'b1011 for a negative sign.
- R7: A final exponent below 0 is underflow. The result is 0 with cc 4'b1100 for a positive sign or 4'b1010 for a negative sign.
- R8: The cc bits are [3] exception, [2] positive, [1] negative, [0] zero (or overflow when [3] is set). A result without an exception has exactly one of bits 2..0 set, according to the result word.
- R9: `done_o` is high for exactly one cycle. It rises on the third rising edge counting the one that samples `start_i`. `busy_o` is high for the two cycles between those edges, and `result_o`/`cc_o` change only when `done_o` rises.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The operation in flight completes with its own operands, and no second `done_o` follows.
- R11: During and right after reset, `busy_o`, `done_o`, `result_o` and `cc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| a_i | input | 32 | First operand word |
| b_i | input | 32 | Second operand word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: result and cc valid |
| result_o | output | 32 | Product word or fixup value |
| cc_o | output | 4 | Condition code {exception, positive, negative, zero/overflow} |

## Verification
Two functions can meet in one cycle. The first is the result presentation: `done_o` rises and `result_o` is updated. The second is the acceptance of a new operation, because the block is already idle in that cycle. The bench raises `start_i` in the exact cycle that `done_o` is seen high. It judges that the presented result still belongs to the first operands, and that the second result arrives after the full latency. A start raised in the middle of the busy window is also driven with operands that would overflow, so a wrongly accepted start would show up as a saturation value.

// File: rtl/hxm_pkg.sv
package hxm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_PACK = 2'd2
    } hxm_state_e;

    localparam int CC_W   = 4;
    localparam int HEX_W  = 4;
endpackage

// File: rtl/hxm_unpack.sv
module hxm_unpack #(
    parameter int WORD_W = 32,
    parameter int FRAC_W = 24
) (
    input  logic [WORD_W-1:0]        op_i,
    output logic                     zero_o,
    output logic [WORD_W-FRAC_W-1:0] exp_o,
    output logic [WORD_W-1:0]        frac_o
);
    logic [WORD_W-1:0] mag;

    always_comb begin
        mag    = op_i[WORD_W-1] ? -op_i : op_i;
        zero_o = (op_i == '0);
        exp_o  = mag[WORD_W-1:FRAC_W];
        frac_o = {1'b0, mag[FRAC_W-1:0], {(WORD_W-FRAC_W-1){1'b0}}};
    end
endmodule

// File: rtl/hxm_norm.sv
module hxm_norm #(
    parameter int VAL_W = 64,
    parameter int OUT_W = 32,
    parameter int STEP  = 4,
    parameter int BIAS  = 64,
    parameter int XW    = 11
) (
    input  logic [VAL_W-1:0]     val_i,
    output logic [OUT_W-1:0]     hi_o,
    output logic signed [XW-1:0] nexp_o
);
    localparam int GUARD = STEP + 1;
    localparam int NSTEP = VAL_W / STEP;

    logic [VAL_W-1:0] v;
    logic             stop;
    logic             is_zero;
    logic [XW-1:0]    cnt;
    logic [GUARD-1:0] top;

    always_comb begin
        v       = val_i;
        is_zero = (val_i == '0);
        stop    = is_zero;
        cnt     = '0;
        top     = '0;
        for (int i = 0; i < NSTEP; i++) begin
            top = v[VAL_W-1 -: GUARD];
            if (!stop) begin
                if (top == '0 || top == '1) begin
                    v   = v << STEP;
                    cnt = cnt + XW'(1);
                end else begin
                    stop = 1'b1;
                end
            end
        end
        hi_o   = v[VAL_W-1 -: OUT_W];
        nexp_o = is_zero ? '0 : $signed(XW'(BIAS) - cnt);
    end
endmodule

// File: rtl/hxm_pack.sv
module hxm_pack #(
    parameter int WORD_W = 32,
    parameter int FRAC_W = 24,
    parameter int XW     = 11,
    parameter int BIAS   = 64
) (
    input  logic [WORD_W-1:0]     hi_i,
    input  logic signed [XW-1:0]  nexp_i,
    input  logic signed [XW-1:0]  sexp_i,
    input  logic                  neg_i,
    output logic [WORD_W-1:0]     res_o,
    output logic [3:0]            cc_o
);
    localparam int EXP_W = WORD_W - FRAC_W - 1;
    localparam int LSB   = WORD_W - 1 - FRAC_W;
    localparam logic [WORD_W-1:0] RND      = WORD_W'(1) << (LSB - 1);
    localparam logic [WORD_W-1:0] POS_MAX  = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_MAX  = {1'b1, {(WORD_W-2){1'b0}}, 1'b1};
    localparam logic [WORD_W-1:0] NO_RND   = POS_MAX - (RND - WORD_W'(1));
    localparam logic [WORD_W-1:0] MINZ     = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] MINZ_FIX = {5'b11111, {(WORD_W-5){1'b0}}};
    localparam logic signed [XW-1:0] EXP_MAX = $signed(XW'((1 << EXP_W) - 1));

    logic [WORD_W-1:0]    hi;
    logic signed [XW-1:0] nexp;
    logic signed [XW-1:0] fexp;
    logic                 skip;
    logic                 unf;
    logic                 ovf;
    logic [EXP_W-1:0]     ef;
    logic [WORD_W-1:0]    word;

    always_comb begin
        hi   = hi_i;
        nexp = nexp_i;
        skip = $signed(hi_i) >= $signed(NO_RND);
        if (!skip && hi_i == MINZ) begin
            hi   = MINZ_FIX;
            nexp = nexp_i + XW'(1);
        end
        if (!skip && nexp == XW'(BIAS)) begin
            hi = hi + RND;
        end
        fexp = nexp + sexp_i;
        unf  = (fexp < 0);
        ovf  = !unf && (fexp > EXP_MAX);
        ef   = fexp[EXP_W-1:0];
        word = {neg_i, (neg_i ? ~ef : ef), hi[WORD_W-2 -: FRAC_W]};
        if (unf) begin
            res_o = '0;
            cc_o  = {1'b1, !neg_i, neg_i, 1'b0};
        end else if (ovf) begin
            res_o = neg_i ? NEG_MAX : POS_MAX;
            cc_o  = {1'b1, !neg_i, neg_i, 1'b1};
        end else begin
            res_o = word;
            cc_o  = {1'b0, (!word[WORD_W-1] && word != '0), word[WORD_W-1], (word == '0)};
        end
    end
endmodule

// File: rtl/hxm_mul.sv
module hxm_mul #(
    parameter int WORD_W = 32,
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o,
    output logic [3:0]        cc_o
);
    import hxm_pkg::*;

    localparam int PROD_W = 2 * WORD_W;
    localparam int XB_W   = WORD_W - FRAC_W;
    localparam int XW     = XB_W + 3;
    localparam int BIAS   = 1 << (XB_W - 2);

    typedef struct packed {
        hxm_state_e           st;
        logic [WORD_W-1:0]    a;
        logic [WORD_W-1:0]    b;
        logic [PROD_W-1:0]    prod;
        logic signed [XW-1:0] sexp;
        logic                 neg;
        logic                 zero;
        logic [WORD_W-1:0]    res;
        logic [CC_W-1:0]      cc;
        logic                 done;
    } regs_t;

    regs_t r_d, r_q;

    logic              za, zb;
    logic [XB_W-1:0]   ea, eb;
    logic [WORD_W-1:0] fa, fb;
    logic [PROD_W-1:0] mult;
    logic [WORD_W-1:0] nhi;
    logic signed [XW-1:0] nexp;
    logic [WORD_W-1:0] pres;
    logic [3:0]        pcc;

    hxm_unpack #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_unp_a (
        .op_i(r_q.a), .zero_o(za), .exp_o(ea), .frac_o(fa)
    );
    hxm_unpack #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_unp_b (
        .op_i(r_q.b), .zero_o(zb), .exp_o(eb), .frac_o(fb)
    );
    hxm_norm #(.VAL_W(PROD_W), .OUT_W(WORD_W), .STEP(HEX_W), .BIAS(BIAS), .XW(XW)) u_norm (
        .val_i(r_q.prod), .hi_o(nhi), .nexp_o(nexp)
    );
    hxm_pack #(.WORD_W(WORD_W), .FRAC_W(FRAC_W), .XW(XW), .BIAS(BIAS)) u_pack (
        .hi_i(nhi), .nexp_i(nexp), .sexp_i(r_q.sexp), .neg_i(r_q.neg),
        .res_o(pres), .cc_o(pcc)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        mult     = (PROD_W'(fa) * PROD_W'(fb)) << 1;
        if (r_q.a[WORD_W-1] ^ r_q.b[WORD_W-1]) begin
            mult = -mult;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.a  = a_i;
                    r_d.b  = b_i;
                    r_d.st = ST_MUL;
                end
            end
            ST_MUL: begin
                r_d.neg  = r_q.a[WORD_W-1] ^ r_q.b[WORD_W-1];
                r_d.zero = za | zb;
                r_d.sexp = $signed(XW'(ea) + XW'(eb) - XW'(2 * BIAS));
                r_d.prod = mult;
                r_d.st   = ST_PACK;
            end
            ST_PACK: begin
                r_d.res  = r_q.zero ? '0 : pres;
                r_d.cc   = r_q.zero ? 4'b0001 : pcc;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = (r_q.st != ST_IDLE);
    assign done_o   = r_q.done;
    assign result_o = r_q.res;
    assign cc_o     = r_q.cc;
endmodule

// File: rtl/hxm_mul_chk.sv
module hxm_mul_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [31:0] result_o,
    input logic [3:0]  cc_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R9
    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |=> (!busy_o && done_o)); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(cc_o))); // R9
    AST_OVF_FIXUP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cc_o[3] && cc_o[0]) |->
            ((result_o == 32'h7FFFFFFF && cc_o[2]) || (result_o == 32'h80000001 && cc_o[1]))); // R6
    AST_UNF_FIXUP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cc_o[3] && !cc_o[0]) |-> (result_o == 32'h0)); // R7
    AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cc_o[3]) |-> ($countones(cc_o[2:0]) == 1)); // R8
    AST_SIGN_CC: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cc_o[3]) |-> (cc_o[1] == result_o[31])); // R2
endmodule

bind hxm_mul hxm_mul_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .cc_o(cc_o)
);

// File: tb/hxm_mul_bench.sv
`timescale 1ns/1ps
module hxm_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;
    logic [3:0]  cc_o;

    int n_checks = 0;
    int n_err    = 0;

    always #4 clk = ~clk;

    hxm_mul u_hxm_mul (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .cc_o(cc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference from the requirements (R1..R8)
    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic [3:0] c);
        logic [31:0] ma, mb, hi;
        logic [63:0] p;
        int ea, eb, nx, fx, n;
        logic s;
        if (a == 0 || b == 0) begin
            r = 0; c = 4'b0001; return;
        end
        s  = a[31] ^ b[31];
        ma = a[31] ? -a : a;
        mb = b[31] ? -b : b;
        ea = int'(ma[31:24]);
        eb = int'(mb[31:24]);
        p  = ({32'b0, ({ma[23:0], 8'h00} >> 1)} * {32'b0, ({mb[23:0], 8'h00} >> 1)}) << 1;
        if (s) p = -p;
        n = 0;
        if (p == 0) nx = 0;
        else begin
            while ((p[63:59] == 5'h00 || p[63:59] == 5'h1f) && n < 16) begin
                p = p << 4; n++;
            end
            nx = 64 - n;
        end
        hi = p[63:32];
        if (!($signed(hi) >= $signed(32'h7FFFFFC0))) begin
            if (hi == 32'h80000000) begin hi = 32'hF8000000; nx++; end
            if (nx == 64) hi = hi + 32'h40;
        end
        fx = nx + ea + eb - 128;
        if (fx < 0) begin
            r = 0; c = {1'b1, !s, s, 1'b0};
        end else if (fx > 127) begin
            r = s ? 32'h80000001 : 32'h7FFFFFFF; c = {1'b1, !s, s, 1'b1};
        end else begin
            r = {s, (s ? ~fx[6:0] : fx[6:0]), hi[30:7]};
            c = r[31] ? 4'b0010 : ((r == 0) ? 4'b0001 : 4'b0100);
        end
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] r, output logic [3:0] c, output int lat);
        @(negedge clk);
        a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        r = result_o;
        c = cc_o;
    endtask

    task automatic op_check(input string req, input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] er, input logic [3:0] ec);
        logic [31:0] r; logic [3:0] c; int lat;
        run_op(a, b, r, c, lat);
        check(req, r, er);
        check(req, {28'b0, c}, {28'b0, ec});
    endtask

    task automatic t_reset;
        check("R11 busy", {31'b0, busy_o}, 32'h0);
        check("R11 done", {31'b0, done_o}, 32'h0);
        check("R11 result", result_o, 32'h0);
        check("R11 cc", {28'b0, cc_o}, 32'h0);
    endtask

    task automatic t_zero;
        op_check("R1 zero b", 32'h41100000, 32'h0, 32'h0, 4'b0001);
        op_check("R1 zero a", 32'h0, 32'hBEF00000, 32'h0, 4'b0001);
    endtask

    task automatic t_exponent;
        op_check("R3 1x1", 32'h41100000, 32'h41100000, 32'h41100000, 4'b0100);
        op_check("R3 15x15", 32'h41F00000, 32'h41F00000, 32'h42E10000, 4'b0100);
        op_check("R3 small", 32'h40100000, 32'h41100000, 32'h40100000, 4'b0100);
    endtask

    task automatic t_sign_norm;
        op_check("R2 R4 neg minus-zero fix", 32'hBEF00000, 32'h41100000, 32'hBEF00000, 4'b0010);
        op_check("R2 neg x neg", 32'hBEF00000, 32'hBEF00000, 32'h41100000, 4'b0100);
        op_check("R4 unnormalized operand", 32'h42010000, 32'h41100000, 32'h41100000, 4'b0100);
    endtask

    task automatic t_round;
        op_check("R5 round carry", 32'h41800001, 32'h41C00000, 32'h42600001, 4'b0100);
    endtask

    task automatic t_range;
        op_check("R6 pos overflow", 32'h7F100000, 32'h7F100000, 32'h7FFFFFFF, 4'b1101);
        op_check("R6 neg overflow", 32'h80F00000, 32'h7F100000, 32'h80000001, 4'b1011);
        op_check("R7 pos underflow", 32'h01100000, 32'h01100000, 32'h0, 4'b1100);
        op_check("R7 neg underflow", 32'hFEF00000, 32'h01100000, 32'h0, 4'b1010);
    endtask

    task automatic t_latency;
        logic [31:0] r; logic [3:0] c; int lat;
        run_op(32'h41100000, 32'h41F00000, r, c, lat);
        check("R9 latency", lat, 3);
        @(negedge clk);
        check("R9 done single", {31'b0, done_o}, 32'h0);
        check("R9 result held", result_o, 32'h41F00000);
    endtask

    task automatic t_ignore;
        @(negedge clk);
        a_i = 32'h41F00000; b_i = 32'h41F00000; start_i = 1'b1;
        @(negedge clk);
        a_i = 32'h7F100000; b_i = 32'h7F100000; start_i = 1'b1;
        check("R10 busy", {31'b0, busy_o}, 32'h1);
        @(negedge clk);
        start_i = 1'b0;
        check("R10 no early done", {31'b0, done_o}, 32'h0);
        @(negedge clk);
        check("R10 done", {31'b0, done_o}, 32'h1);
        check("R10 first operands kept", result_o, 32'h42E10000);
        @(negedge clk);
        @(negedge clk);
        check("R10 no second op busy", {31'b0, busy_o}, 32'h0);
        check("R10 no second done", {31'b0, done_o}, 32'h0);
    endtask

    task automatic t_back_to_back;
        logic [31:0] r; logic [3:0] c; int lat;
        run_op(32'h41100000, 32'h41100000, r, c, lat);
        a_i = 32'h7F100000; b_i = 32'h7F100000; start_i = 1'b1;
        check("R9 b2b first result", result_o, 32'h41100000);
        @(negedge clk);
        start_i = 1'b0;
        check("R9 b2b accepted", {31'b0, busy_o}, 32'h1);
        @(negedge clk);
        @(negedge clk);
        check("R9 b2b second done", {31'b0, done_o}, 32'h1);
        check("R9 b2b second result", result_o, 32'h7FFFFFFF);
    endtask

    task automatic t_sweep;
        logic [31:0] x, er, r;
        logic [3:0]  ec, c;
        int lat;
        x = 32'hACE1_2468;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b;
            x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
            a = {x[31], 2'b10, x[28:0]};
            x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
            b = (i % 5 == 0) ? x : {x[31], 2'b01, x[28:0]};
            model(a, b, er, ec);
            run_op(a, b, r, c, lat);
            check("R4 R5 R8 sweep result", r, er);
            check("R8 sweep cc", {28'b0, c}, {28'b0, ec});
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_exponent();
        t_sign_norm();
        t_round();
        t_range();
        t_latency();
        t_ignore();
        t_back_to_back();
        t_sweep();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule